// File: doc/BRIEF.md
# Triggered One-Pulse Generator

This block is a small up-counting timer that sits idle until its external trigger pin rises. The trigger is brought into the clock domain through a synchronizer, and its rising edge starts the counter from zero. The counter advances once per clock up to a programmed period and then rolls back to zero. That rollover raises a one-cycle update event. When single-shot operation is selected, the counter stops at that first rollover. It then waits, parked at zero, for the next trigger edge.

The output stage compares the count against a programmed compare value. In the delayed-pulse mode, the output rises once the count reaches the compare value and falls when the count reaches the period. The delay is therefore compare cycles and the width is period minus compare. A second comparison mode inverts the sense. Two static modes hold the output low or high. A fast-start option treats the compare as already matched from the moment the trigger edge is seen, so the output needs no counting to respond.

The control state machine has two states. ST_IDLE holds the counter clear and leaves it only by the transition T_START, taken on a synchronized rising edge. ST_RUN counts. At the period value it takes one of two transitions: T_WRAP, which stays in ST_RUN when single-shot is off, or T_STOP, which returns to ST_IDLE when single-shot is on.

Top module: `one_pulse_gen`

## Requirements
- R1: A rising edge on `trig_in` passes through a two-flop synchronizer and an edge register. `running` goes high after the third rising clock edge that samples `trig_in` high, with the count at 0.
- R2: While running, the count rises by one per clock from 0 to `period`, then wraps to 0. `update_evt` is high for exactly the one cycle that follows each wrap.
- R3: With `one_pulse_en` = 1, the run ends at the first wrap. `running` falls in the same cycle that `update_evt` is high, so a run lasts `period`+1 cycles. The count then stays at 0.
- R4: With `one_pulse_en` = 0, the counter keeps wrapping and running. Setting `one_pulse_en` during a run stops the counter at the next wrap.
- R5: Trigger edges that arrive while running are ignored. They neither restart nor extend the run.
- R6: With `mode_sel` = 2'b11 (delayed pulse) and `fast_en` = 0, `pulse_out` is high while running when compare ≠ 0 and compare ≤ count < period. This gives a delay of compare cycles and a width of period − compare. A compare of 0, or a compare ≥ period, yields no pulse.
- R7: With `mode_sel` = 2'b10 (early pulse) and `fast_en` = 0, `pulse_out` is high while running whenever count < compare.
- R8: With `mode_sel` = 2'b00 the output is held low, and with 2'b01 it is held high. In both cases this holds whether or not the counter runs, and `fast_en` has no effect.
- R9: With `fast_en` = 1 in mode 2'b11, `pulse_out` is high in the cycle the start edge is detected and stays high while running with count < period. In mode 2'b10 with `fast_en` = 1, the output stays low.
- R10: When idle in modes 2'b10 and 2'b11, `pulse_out` is low, except during the fast start cycle of R9.
- R11: After reset, `running`, `update_evt` and `pulse_out` are 0, and the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_in | input | 1 | Asynchronous external trigger |
| period | input | CNT_W | Last count value before wrap |
| compare | input | CNT_W | Compare value (pulse delay) |
| mode_sel | input | 2 | 00 low, 01 high, 10 early pulse, 11 delayed pulse |
| one_pulse_en | input | 1 | Stop at first wrap |
| fast_en | input | 1 | Treat compare as matched from the trigger edge |
| pulse_out | output | 1 | Pulse output |
| running | output | 1 | Counter active |
| update_evt | output | 1 | One-cycle pulse after each wrap |

## Verification
The assertions take for granted that `period` and `compare` do not change while the counter runs. The count bound and the output window are only meaningful under that assumption. The stimulus therefore changes those values, and the mode, only while the block is idle. The single exception is `one_pulse_en`, which is deliberately set in the middle of a run. Each trigger pulse is released before the run can end, so that no stray edge lands in idle. The run length is at least six cycles whenever a trigger is deliberately pulsed during the run.

// File: rtl/opg_pkg.sv
package opg_pkg;

    typedef enum logic [1:0] {
        OUT_LOW   = 2'b00,
        OUT_HIGH  = 2'b01,
        OUT_EARLY = 2'b10,
        OUT_DELAY = 2'b11
    } out_mode_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

endpackage

// File: rtl/opg_trig_sync.sv
module opg_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= trig_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign rise_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/opg_counter.sv
module opg_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             count_en,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             at_top
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    assign at_top = (cnt_q == period);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (clear)    cnt_q <= '0;
        else if (count_en) cnt_q <= at_top ? '0 : cnt_q + ONE;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/opg_ctrl_fsm.sv
module opg_ctrl_fsm
    import opg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    input  logic at_top,
    input  logic one_shot,
    output logic running,
    output logic count_en,
    output logic clear,
    output logic start,
    output logic update_evt
);
    run_state_e state_q, state_d;
    logic       upd_q;
    logic       wrap;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: T_START, T_WRAP, T_STOP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rise_i) state_d = ST_RUN;
            ST_RUN:  if (at_top && one_shot) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        running  = 1'b0;
        count_en = 1'b0;
        clear    = 1'b0;
        start    = 1'b0;
        wrap     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                clear = 1'b1;
                start = rise_i;
            end
            ST_RUN: begin
                running  = 1'b1;
                count_en = 1'b1;
                wrap     = at_top;
            end
            default: clear = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) upd_q <= 1'b0;
        else        upd_q <= wrap;
    end

    assign update_evt = upd_q;
endmodule

// File: rtl/opg_out_stage.sv
module opg_out_stage
    import opg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [1:0]       mode_sel,
    input  logic             fast_en,
    input  logic             running,
    input  logic             start,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] compare,
    input  logic [CNT_W-1:0] period,
    output logic             pulse_out
);
    out_mode_e mode;
    logic      below_cmp;
    logic      below_top;
    logic      in_window;

    assign mode      = out_mode_e'(mode_sel);
    assign below_cmp = (cnt < compare);
    assign below_top = (cnt < period);
    assign in_window = (compare != '0) && !below_cmp && below_top;

    always_comb begin
        unique case (mode)
            OUT_LOW:   pulse_out = 1'b0;
            OUT_HIGH:  pulse_out = 1'b1;
            OUT_EARLY: pulse_out = fast_en ? 1'b0 : (running && below_cmp);
            OUT_DELAY: pulse_out = fast_en ? (start || (running && below_top))
                                           : (running && in_window);
            default:   pulse_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/one_pulse_gen.sv
module one_pulse_gen #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_in,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] compare,
    input  logic [1:0]       mode_sel,
    input  logic             one_pulse_en,
    input  logic             fast_en,
    output logic             pulse_out,
    output logic             running,
    output logic             update_evt
);
    logic             rise;
    logic             at_top;
    logic             count_en;
    logic             clear;
    logic             start_pulse;
    logic [CNT_W-1:0] cnt_q;

    opg_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_in(trig_in),
        .rise_o (rise)
    );

    opg_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (rise),
        .at_top    (at_top),
        .one_shot  (one_pulse_en),
        .running   (running),
        .count_en  (count_en),
        .clear     (clear),
        .start     (start_pulse),
        .update_evt(update_evt)
    );

    opg_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .count_en(count_en),
        .period  (period),
        .cnt     (cnt_q),
        .at_top  (at_top)
    );

    opg_out_stage #(.CNT_W(CNT_W)) u_out (
        .mode_sel (mode_sel),
        .fast_en  (fast_en),
        .running  (running),
        .start    (start_pulse),
        .cnt      (cnt_q),
        .compare  (compare),
        .period   (period),
        .pulse_out(pulse_out)
    );
endmodule

// File: rtl/one_pulse_gen_chk.sv
module one_pulse_gen_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             running,
    input logic             update_evt,
    input logic             pulse_out,
    input logic             start,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] period,
    input logic [1:0]       mode_sel,
    input logic             one_pulse_en,
    input logic             fast_en
);
    p_start_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> (cnt == '0) && $past(start));

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> cnt <= period);

    p_update_after_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cnt == period) |=> update_evt && cnt == '0);

    p_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cnt == period && one_pulse_en) |=> !running);

    p_keep_running_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cnt != period) |=> running);

    p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> cnt == '0);

    p_static_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b01) |-> pulse_out);

    p_fast_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && fast_en && mode_sel == 2'b11) |-> pulse_out);

    p_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !start && mode_sel[1]) |-> !pulse_out);
endmodule

bind one_pulse_gen one_pulse_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .running     (running),
    .update_evt  (update_evt),
    .pulse_out   (pulse_out),
    .start       (start_pulse),
    .cnt         (cnt_q),
    .period      (period),
    .mode_sel    (mode_sel),
    .one_pulse_en(one_pulse_en),
    .fast_en     (fast_en)
);

// File: tb/one_pulse_gen_test.sv
module one_pulse_gen_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         trig_in = 1'b0;
    logic [W-1:0] period = '0;
    logic [W-1:0] compare = '0;
    logic [1:0]   mode_sel = 2'b11;
    logic         one_pulse_en = 1'b1;
    logic         fast_en = 1'b0;
    logic         pulse_out, running, update_evt;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    one_pulse_gen #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .period(period),
        .compare(compare), .mode_sel(mode_sel), .one_pulse_en(one_pulse_en),
        .fast_en(fast_en), .pulse_out(pulse_out), .running(running),
        .update_evt(update_evt)
    );

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_out(logic [1:0] m, logic f, int c, int p, int i);
        case (m)
            2'b00:   return 1'b0;
            2'b01:   return 1'b1;
            2'b10:   return f ? 1'b0 : (i < c);
            default: return f ? (i < p) : (c != 0 && i >= c && i < p);
        endcase
    endfunction

    function automatic logic exp_idle(logic [1:0] m);
        return m == 2'b01;
    endfunction

    function automatic logic exp_edge(logic [1:0] m, logic f);
        return (m == 2'b01) || (m == 2'b11 && f);
    endfunction

    // one single-shot run; retrig pulses the trigger while counting
    task automatic run_one(input logic [1:0] m, input logic f, input int c,
                           input int p, input bit retrig);
        @(negedge clk);
        mode_sel = m; fast_en = f; compare = c[W-1:0]; period = p[W-1:0];
        one_pulse_en = 1'b1; trig_in = 1'b0;
        repeat (3) @(negedge clk);
        check(running, 1'b0, "R10 idle running");
        check(pulse_out, exp_idle(m), "R10 idle output");
        trig_in = 1'b1;
        @(negedge clk);
        check(running, 1'b0, "R1 after first edge");
        @(negedge clk);
        check(running, 1'b0, "R1 after second edge");
        check(pulse_out, exp_edge(m, f), "R9 start cycle output");
        trig_in = 1'b0;
        for (int i = 0; i <= p; i++) begin
            @(negedge clk);
            check(running, 1'b1, "R1 running during run");
            check(update_evt, 1'b0, "R2 no update mid-run");
            check(pulse_out, exp_out(m, f, c, p, i), "R6 R7 R8 R9 output vs count");
            if (retrig && i == 1) trig_in = 1'b1;
            if (retrig && i == 3) trig_in = 1'b0;
        end
        @(negedge clk);
        check(running, 1'b0, "R3 stopped after wrap");
        check(update_evt, 1'b1, "R2 update after wrap");
        check(pulse_out, exp_idle(m), "R10 output idle after stop");
        @(negedge clk);
        check(update_evt, 1'b0, "R2 update one cycle");
        check(running, 1'b0, "R5 no restart from ignored edge");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check(running, 1'b0, "R11 reset running");
        check(update_evt, 1'b0, "R11 reset update");
        check(pulse_out, 1'b0, "R11 reset output");
        rst_n = 1'b1;

        // directed corners
        run_one(2'b11, 1'b0, 3, 8, 1'b1);   // R6 delay 3, width 5; R5 retrigger
        run_one(2'b11, 1'b0, 0, 5, 1'b0);   // R6 compare zero: no pulse
        run_one(2'b11, 1'b0, 9, 6, 1'b0);   // R6 compare beyond period
        run_one(2'b11, 1'b0, 4, 0, 1'b0);   // R3 zero period
        run_one(2'b10, 1'b0, 4, 7, 1'b0);   // R7 early pulse
        run_one(2'b11, 1'b1, 5, 7, 1'b0);   // R9 fast delayed
        run_one(2'b10, 1'b1, 5, 7, 1'b1);   // R9 fast early stays low
        run_one(2'b00, 1'b1, 2, 6, 1'b0);   // R8 held low
        run_one(2'b01, 1'b1, 2, 6, 1'b0);   // R8 held high

        // R4 continuous mode, single-shot set during the third period
        @(negedge clk);
        mode_sel = 2'b11; fast_en = 1'b0; compare = 16'd2; period = 16'd4;
        one_pulse_en = 1'b0;
        repeat (3) @(negedge clk);
        trig_in = 1'b1;
        repeat (2) @(negedge clk);
        trig_in = 1'b0;
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i <= 4; i++) begin
                @(negedge clk);
                check(running, 1'b1, "R4 keeps running");
                check(update_evt, (r > 0 && i == 0), "R4 R2 update per wrap");
                check(pulse_out, exp_out(2'b11, 1'b0, 2, 4, i), "R4 R6 repeated pulse");
                if (r == 2 && i == 1) one_pulse_en = 1'b1;
            end
        end
        @(negedge clk);
        check(running, 1'b0, "R4 stop at next wrap");
        check(update_evt, 1'b1, "R4 final update");

        // constrained random runs
        for (int k = 0; k < 30; k++) begin
            int p, c;
            logic [1:0] m;
            logic f;
            p = $urandom_range(0, 15);
            c = $urandom_range(0, 17);
            m = 2'($urandom_range(0, 3));
            f = 1'($urandom_range(0, 1));
            run_one(m, f, c, p, p >= 6);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule